// File: doc/BRIEF.md
# UART Interrupt Priority and Identification Unit

This unit sits beside a UART datapath and collects its four interrupt conditions: a receive line error, a received character waiting, the transmit holding register becoming empty, and a change on the modem handshake inputs. Each condition is latched as a pending flag. A per-source enable mask then decides whether the flag drives the single interrupt request line.

The host reads an identification byte that names only the most urgent enabled pending source. Each pending flag is cleared by the host access that services it. A receive error clears on a read of the line status register. A received character clears on a read of the receive buffer. A modem change clears on a read of the modem status register. A transmit-empty flag clears on a write of the holding register, or on a read of the identification byte while that byte reports transmit-empty. The datapath supplies one-cycle event pulses for the receive error, the received character and the modem change, plus a level that shows whether the holding register is empty. The host side supplies read and write strobes together with the register select code.

Top module: `uart_irq_id`

## Requirements
- R1: The identification byte has bit 0 = 0 when any enabled source is pending and 1 when none is pending. Bits 2:1 give the reported source: 11 line error, 10 received data, 01 transmit empty, 00 modem change. Bits 7:3 read 0, so the idle value is 0x01.
- R2: Sources are reported in fixed priority: line error, then received data, then transmit empty, then modem change.
- R3: `irq` is high exactly when at least one pending source is also enabled.
- R4: A read strobe with select 0 (receive buffer) clears the received-data flag, and only that flag.
- R5: A read strobe with select 5 (line status) clears the line-error flag. A write strobe with select 5 has no effect.
- R6: A read strobe with select 6 (modem status) clears the modem-change flag. A read of the identification byte (select 2) leaves it set.
- R7: A read strobe with select 2 clears the transmit-empty flag only while the identification byte reports transmit-empty (code 0x02). Otherwise the flag stays set.
- R8: A write strobe with select 0 (holding register) clears the transmit-empty flag.
- R9: A low-to-high transition of `thr_empty` sets the transmit-empty flag. A level that stays high does not set it again after it has been cleared.
- R10: A 0-to-1 change of enable bit 1 while `thr_empty` is high sets the transmit-empty flag at once.
- R11: Pending flags latch whatever the enable mask says. Enable bit 0 gates received data, bit 1 transmit empty, bit 2 line error and bit 3 modem change. A flag latched while masked is reported once its bit is enabled.
- R12: After reset no flag is pending, `irq` is low and the identification byte reads 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_line_err | input | 1 | One-cycle pulse: receive line error detected |
| ev_rx_data | input | 1 | One-cycle pulse: character placed in the receive buffer |
| ev_modem | input | 1 | One-cycle pulse: modem input change detected |
| thr_empty | input | 1 | Level: transmit holding register is empty |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 3 | Register select of the current host access |
| irq_en | input | 4 | Enable mask (bit 0 rx data, 1 tx empty, 2 line error, 3 modem) |
| irq | output | 1 | Interrupt request |
| irq_ident | output | 8 | Identification byte |

## Verification
The bench uses the default parameters: a 3-bit select with codes 0, 2, 5 and 6, and an 8-bit identification byte. With only four sources, it can walk all 16 pending patterns against all 16 enable masks and compute the expected code and request level for each of the 256 pairs. The defaults also make every clear rule reachable through a handful of directed accesses. These include the conditional clear of transmit-empty when a higher source is in front of it, and re-arming on a fresh empty edge or enable edge.

// File: rtl/uart_irq_id.sv
module uart_irq_id #(
  parameter int SEL_W     = 3,
  parameter int ID_W      = 8,
  parameter int SEL_DATA  = 0,
  parameter int SEL_IDENT = 2,
  parameter int SEL_LINE  = 5,
  parameter int SEL_MODEM = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_line_err,
  input  logic            ev_rx_data,
  input  logic            ev_modem,
  input  logic            thr_empty,
  input  logic            host_rd,
  input  logic            host_wr,
  input  logic [SEL_W-1:0] host_sel,
  input  logic [3:0]      irq_en,
  output logic            irq,
  output logic [ID_W-1:0] irq_ident
);
  localparam int RX = 0, TX = 1, LN = 2, MD = 3;
  localparam logic [SEL_W-1:0] S_DATA  = SEL_W'(SEL_DATA);
  localparam logic [SEL_W-1:0] S_IDENT = SEL_W'(SEL_IDENT);
  localparam logic [SEL_W-1:0] S_LINE  = SEL_W'(SEL_LINE);
  localparam logic [SEL_W-1:0] S_MODEM = SEL_W'(SEL_MODEM);

  logic [3:0] pend, act, set, clr;
  logic       thr_q, tx_en_q;
  logic [2:0] code;

  assign act = pend & irq_en;
  assign irq = |act;

  always_comb begin
    if      (act[LN]) code = 3'b110;
    else if (act[RX]) code = 3'b100;
    else if (act[TX]) code = 3'b010;
    else if (act[MD]) code = 3'b000;
    else              code = 3'b001;
  end

  assign irq_ident = {{(ID_W-3){1'b0}}, code};

  assign set[LN] = ev_line_err;
  assign set[RX] = ev_rx_data;
  assign set[MD] = ev_modem;
  assign set[TX] = (thr_empty & ~thr_q) | (thr_empty & irq_en[TX] & ~tx_en_q);

  assign clr[LN] = host_rd && host_sel == S_LINE;
  assign clr[RX] = host_rd && host_sel == S_DATA;
  assign clr[MD] = host_rd && host_sel == S_MODEM;
  assign clr[TX] = (host_wr && host_sel == S_DATA) ||
                   (host_rd && host_sel == S_IDENT && code == 3'b010);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= '0;
      thr_q   <= 1'b1;
      tx_en_q <= 1'b1;
    end else begin
      pend    <= set | (pend & ~clr);
      thr_q   <= thr_empty;
      tx_en_q <= irq_en[TX];
    end
  end
endmodule

module uart_irq_id_chk #(
  parameter int SEL_W     = 3,
  parameter int ID_W      = 8,
  parameter int SEL_DATA  = 0,
  parameter int SEL_IDENT = 2,
  parameter int SEL_LINE  = 5,
  parameter int SEL_MODEM = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_line_err,
  input logic             ev_rx_data,
  input logic             ev_modem,
  input logic             thr_empty,
  input logic             host_rd,
  input logic             host_wr,
  input logic [SEL_W-1:0] host_sel,
  input logic [3:0]       irq_en,
  input logic             irq,
  input logic [ID_W-1:0]  irq_ident
);
  assert_irq_matches_ident_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq != irq_ident[0]);

  assert_rx_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_sel == SEL_W'(SEL_DATA) && !ev_rx_data) |=> irq_ident[3:0] != 4'b0100);

  assert_line_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_sel == SEL_W'(SEL_LINE) && !ev_line_err) |=> irq_ident[3:0] != 4'b0110);

  assert_modem_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_sel == SEL_W'(SEL_MODEM) && !ev_modem) |=> irq_ident[3:0] != 4'b0000);

  assert_thr_write_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel == SEL_W'(SEL_DATA) && !$rose(thr_empty) && !$rose(irq_en[1]))
      |=> irq_ident[3:0] != 4'b0010);

  assert_empty_edge_raises_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(thr_empty) && irq_en[1] && $stable(irq_en[1])) |=> irq);

  assert_enable_edge_raises_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_en[1]) && thr_empty) |=> irq);
endmodule

bind uart_irq_id uart_irq_id_chk #(
  .SEL_W(SEL_W), .ID_W(ID_W), .SEL_DATA(SEL_DATA), .SEL_IDENT(SEL_IDENT),
  .SEL_LINE(SEL_LINE), .SEL_MODEM(SEL_MODEM)
) u_chk (.*);

// File: tb/tb_uart_irq_id.sv
`timescale 1ns/1ps
module tb_uart_irq_id;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_line_err = 0, ev_rx_data = 0, ev_modem = 0, thr_empty = 0;
  logic       host_rd = 0, host_wr = 0;
  logic [2:0] host_sel = '0;
  logic [3:0] irq_en = '0;
  logic       irq;
  logic [7:0] irq_ident;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_irq_id dut (.*);

  function automatic logic [7:0] exp_id(input logic [3:0] p, input logic [3:0] e);
    logic [3:0] a;
    a = p & e;
    if (a[2]) return 8'h06;
    if (a[0]) return 8'h04;
    if (a[1]) return 8'h02;
    if (a[3]) return 8'h00;
    return 8'h01;
  endfunction

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; ev_line_err = 0; ev_rx_data = 0; ev_modem = 0; thr_empty = 0;
    host_rd = 0; host_wr = 0; host_sel = 0; irq_en = 0;
    tick(2);
    @(negedge clk);
    rst_n = 1;
    tick(1);
  endtask

  task automatic pulse(input logic ln, input logic rx, input logic md);
    @(negedge clk);
    ev_line_err = ln; ev_rx_data = rx; ev_modem = md;
    tick(1);
    @(negedge clk);
    ev_line_err = 0; ev_rx_data = 0; ev_modem = 0;
  endtask

  task automatic access(input logic rd, input logic [2:0] sel);
    @(negedge clk);
    host_rd = rd; host_wr = !rd; host_sel = sel;
    tick(1);
    @(negedge clk);
    host_rd = 0; host_wr = 0;
  endtask

  task automatic set_empty(input logic v);
    @(negedge clk);
    thr_empty = v;
    tick(1);
  endtask

  task automatic set_en(input logic [3:0] v);
    @(negedge clk);
    irq_en = v;
    tick(1);
  endtask

  initial begin
    do_reset();
    chk("R12 ident", irq_ident, 8'h01);
    chk("R12 irq", {7'b0, irq}, 8'h00);

    // R1 R2 R3 R11: exhaustive pending x enable sweep
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 16; p++) begin
        do_reset();
        @(negedge clk);
        ev_rx_data = p[0]; ev_line_err = p[2]; ev_modem = p[3]; thr_empty = p[1];
        tick(1);
        @(negedge clk);
        ev_rx_data = 0; ev_line_err = 0; ev_modem = 0;
        irq_en = 4'(m);
        tick(2);
        chk("R1/R2/R11 ident", irq_ident, exp_id(4'(p), 4'(m)));
        chk("R3 irq", {7'b0, irq}, {7'b0, |(4'(p) & 4'(m))});
      end
    end

    do_reset();
    set_en(4'hF);
    // R4
    pulse(0, 1, 0);
    chk("R4 rx pending", irq_ident, 8'h04);
    pulse(1, 0, 0);
    access(1, 3'd0);
    chk("R4 rx read leaves line", irq_ident, 8'h06);
    // R5
    access(0, 3'd5);
    chk("R5 write ignored", irq_ident, 8'h06);
    access(1, 3'd5);
    chk("R5 line read clears", irq_ident, 8'h01);
    // R6
    pulse(0, 0, 1);
    chk("R6 modem pending", irq_ident, 8'h00);
    access(1, 3'd2);
    chk("R6 ident read keeps modem", irq_ident, 8'h00);
    access(1, 3'd6);
    chk("R6 modem read clears", irq_ident, 8'h01);
    // R7
    pulse(1, 0, 0);
    set_empty(1);
    chk("R7 line before tx", irq_ident, 8'h06);
    access(1, 3'd2);
    access(1, 3'd5);
    chk("R7 tx survives unreported read", irq_ident, 8'h02);
    access(1, 3'd2);
    chk("R7 reported read clears tx", irq_ident, 8'h01);
    // R9
    tick(3);
    chk("R9 steady level no re-raise", irq_ident, 8'h01);
    set_empty(0);
    set_empty(1);
    chk("R9 new edge raises", irq_ident, 8'h02);
    // R8
    access(0, 3'd0);
    chk("R8 holding write clears", irq_ident, 8'h01);
    chk("R8 irq low", {7'b0, irq}, 8'h00);
    // R10
    set_en(4'h0);
    set_en(4'h2);
    chk("R10 enable edge raises", irq_ident, 8'h02);
    access(1, 3'd2);
    chk("R10 cleared", irq_ident, 8'h01);
    set_en(4'h0);
    pulse(0, 0, 1);
    chk("R11 masked modem silent", {7'b0, irq}, 8'h00);
    set_en(4'h8);
    chk("R11 enabled modem reported", irq_ident, 8'h00);
    chk("R11 irq", {7'b0, irq}, 8'h01);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule